// File: doc/BRIEF.md
# Trimmed One-Second Prescaler

This block turns an oscillator enable that pulses at the nominal 32768 Hz crystal rate into a one-clock tick once per second. A signed digital trim adjusts the tick rate. Instead of changing every second a little, the block corrects a single second in some of the minutes of a repeating 64-minute cycle. The minutes come from a strobe that the calendar logic sends back, one strobe per minute.

The divider has two stages. A low stage divides by 256, and a high stage counts those carries up to one second. The correction acts at the carry between the two stages. A positive trim makes the high stage take a double step once, so the second ends 256 oscillator counts early. A negative trim holds the low stage for half a wrap, 128 counts, so the second ends 128 counts late. With a trim magnitude N, minutes 0 to 2N-1 of the cycle are corrected and the other minutes are not. A separate counter that the trim never touches gives a 512 Hz square wave, which is used to measure the oscillator. A stop input freezes and clears the whole chain.

Top module: `cal_trim_divider`

## Requirements
- R1: With no correction pending, `sec_tick` is high for exactly one clock after every HI_DIV*256 enables (32768 by default). The first tick after reset comes after that many enables.
- R2: The minute index starts at 63 after reset. Each `min_stb` pulse moves it forward by one, and from 63 it goes back to 0.
- R3: A strobe arms a correction only when the new minute index is below 2*`trim_mag`. A magnitude of 0 never arms one. A magnitude of 31 arms minutes 0 to 61 and leaves minutes 62 and 63 alone.
- R4: When a correction is armed and `trim_pos` is 1, the corrected second lasts 256 enables fewer than nominal.
- R5: When a correction is armed and `trim_pos` is 0, the corrected second lasts 128 enables more than nominal. During those 128 enables the low stage holds its value.
- R6: One arming corrects exactly one second. It is the second whose first 256-enable carry comes after the strobe: this is the running second if the strobe arrives inside its first 256 enables, and otherwise the next second.
- R7: `ftest` toggles once every 32 enables (512 Hz at the nominal rate), whatever the trim and any correction in progress. After reset it is 0.
- R8: While `halt` is high there is no tick, and the divider and `ftest` are held at zero. The minute index and any armed correction are kept. After `halt` is released, the first tick comes after a full second of enables, with that second corrected if a correction is armed.
- R9: Only clocks with `osc_en` high advance the divider and the test counter. With enables on every second clock, the measured second is twice as long in clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | One pulse per oscillator cycle |
| trim_mag | input | MAG_W | Trim magnitude, 0 to 31 |
| trim_pos | input | 1 | Trim sign: 1 speeds up, 0 slows down |
| halt | input | 1 | Stops and clears the divider chain |
| min_stb | input | 1 | One-clock minute strobe from the calendar |
| sec_tick | output | 1 | One-clock tick per corrected second |
| ftest | output | 1 | 512 Hz square wave that the trim does not affect |

## Verification
The checker tests on every clock the properties that involve only one or two cycles:
- the tick is a single-cycle pulse and is absent while halted;
- the test output stays still while halted;
- the minute index wraps from 63 to 0;
- a zero magnitude never arms a correction;
- the low stage is frozen during a blank.

Whole-second lengths cannot be checked that way. These include the 256-count shortening, the 128-count lengthening, which minute of the window gets a correction, a correction that arrives late and moves to the next second, and the 32-enable spacing of the test output under correction and gapped enables. Only the bench's scoreboard of measured intervals shows those.

// File: rtl/cal_pkg.sv
package cal_pkg;

  // Minute index after a strobe; wraps from the last minute back to zero.
  function automatic int unsigned next_minute(input int unsigned idx, input int unsigned cycle_len);
    return (idx + 1 >= cycle_len) ? 0 : idx + 1;
  endfunction

  // A minute is corrected when it lies in the first 2*mag minutes of the cycle.
  function automatic logic in_window(input int unsigned idx, input int unsigned mag);
    return idx < 2 * mag;
  endfunction

  // High-stage step: wrap at top, double step when a speed-up is injected.
  function automatic int unsigned hi_next(input int unsigned cur, input int unsigned top,
                                          input logic skip);
    if (cur == top) return 0;
    return cur + (skip ? 2 : 1);
  endfunction

endpackage

// File: rtl/cal_seq.sv
module cal_seq #(
  parameter int MAG_W     = 5,
  parameter int CYCLE_MIN = 64,
  localparam int MIN_W    = $clog2(CYCLE_MIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             min_stb,
  input  logic [MAG_W-1:0] mag,
  input  logic             consume,
  output logic             arm,
  output logic [MIN_W-1:0] min_idx
);
  import cal_pkg::*;

  logic [MIN_W-1:0] nxt_idx;

  always_comb nxt_idx = MIN_W'(next_minute(32'(min_idx), CYCLE_MIN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      min_idx <= MIN_W'(CYCLE_MIN - 1);
      arm     <= 1'b0;
    end else if (min_stb) begin
      min_idx <= nxt_idx;
      arm     <= in_window(32'(nxt_idx), 32'(mag));
    end else if (consume) begin
      arm     <= 1'b0;
    end
  end
endmodule

// File: rtl/cal_low_stage.sv
module cal_low_stage #(
  parameter int LOW_W      = 8,
  localparam int BLANK_LEN = 2 ** (LOW_W - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             halt,
  input  logic             start_blank,
  output logic             low_wrap,
  output logic             blank_active,
  output logic [LOW_W-1:0] low_cnt
);
  logic [LOW_W-1:0] blank_cnt;

  assign blank_active = (blank_cnt != '0);
  assign low_wrap     = en && !halt && !blank_active && (low_cnt == '1);

  always_ff @(posedge clk) begin
    if (!rst_n || halt) begin
      low_cnt   <= '0;
      blank_cnt <= '0;
    end else if (en) begin
      if (blank_active) begin
        blank_cnt <= blank_cnt - 1'b1;
      end else begin
        low_cnt <= low_cnt + 1'b1;
        if (start_blank) blank_cnt <= LOW_W'(BLANK_LEN);
      end
    end
  end
endmodule

// File: rtl/cal_high_stage.sv
module cal_high_stage #(
  parameter int HI_DIV = 128,
  localparam int HI_W  = $clog2(HI_DIV)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  input  logic low_wrap,
  input  logic skip,
  output logic hi_zero,
  output logic sec_end
);
  import cal_pkg::*;

  logic [HI_W-1:0] hi_cnt;
  logic            at_top;

  assign at_top  = (hi_cnt == HI_W'(HI_DIV - 1));
  assign hi_zero = (hi_cnt == '0);
  assign sec_end = low_wrap && at_top;

  always_ff @(posedge clk) begin
    if (!rst_n || halt) hi_cnt <= '0;
    else if (low_wrap)  hi_cnt <= HI_W'(hi_next(32'(hi_cnt), HI_DIV - 1, skip));
  end
endmodule

// File: rtl/cal_ftest.sv
module cal_ftest #(
  parameter int HALF = 32,
  localparam int W   = $clog2(HALF)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic halt,
  output logic ftest
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || halt) begin
      cnt   <= '0;
      ftest <= 1'b0;
    end else if (en) begin
      if (cnt == W'(HALF - 1)) begin
        cnt   <= '0;
        ftest <= !ftest;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cal_trim_divider.sv
module cal_trim_divider #(
  parameter int LOW_W     = 8,
  parameter int HI_DIV    = 128,
  parameter int MAG_W     = 5,
  parameter int CYCLE_MIN = 64,
  parameter int FT_HALF   = 32,
  localparam int MIN_W    = $clog2(CYCLE_MIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic [MAG_W-1:0] trim_mag,
  input  logic             trim_pos,
  input  logic             halt,
  input  logic             min_stb,
  output logic             sec_tick,
  output logic             ftest
);
  logic             low_wrap, blank_active, hi_zero, sec_end, arm;
  logic [LOW_W-1:0] low_cnt;
  logic [MIN_W-1:0] min_idx;
  logic             consume, skip_now, blank_start;

  // The correction is taken at the first carry out of the low stage in a second.
  assign consume     = low_wrap && hi_zero && arm;
  assign skip_now    = consume && trim_pos;
  assign blank_start = consume && !trim_pos;

  cal_seq #(.MAG_W(MAG_W), .CYCLE_MIN(CYCLE_MIN)) u_seq (
    .clk(clk), .rst_n(rst_n), .min_stb(min_stb), .mag(trim_mag),
    .consume(consume), .arm(arm), .min_idx(min_idx));

  cal_low_stage #(.LOW_W(LOW_W)) u_low (
    .clk(clk), .rst_n(rst_n), .en(osc_en), .halt(halt), .start_blank(blank_start),
    .low_wrap(low_wrap), .blank_active(blank_active), .low_cnt(low_cnt));

  cal_high_stage #(.HI_DIV(HI_DIV)) u_high (
    .clk(clk), .rst_n(rst_n), .halt(halt), .low_wrap(low_wrap), .skip(skip_now),
    .hi_zero(hi_zero), .sec_end(sec_end));

  cal_ftest #(.HALF(FT_HALF)) u_ft (
    .clk(clk), .rst_n(rst_n), .en(osc_en), .halt(halt), .ftest(ftest));

  always_ff @(posedge clk) begin
    if (!rst_n) sec_tick <= 1'b0;
    else        sec_tick <= sec_end;
  end
endmodule

// File: rtl/cal_trim_divider_chk.sv
module cal_trim_divider_chk #(
  parameter int LOW_W     = 8,
  parameter int MAG_W     = 5,
  parameter int CYCLE_MIN = 64,
  localparam int MIN_W    = $clog2(CYCLE_MIN)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halt,
  input logic             min_stb,
  input logic [MAG_W-1:0] trim_mag,
  input logic             sec_tick,
  input logic             ftest,
  input logic [MIN_W-1:0] min_idx,
  input logic             arm,
  input logic             blank_active,
  input logic [LOW_W-1:0] low_cnt
);
  // R1
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  // R8
  no_tick_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !sec_tick);

  // R8
  ftest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && $past(halt)) |=> $stable(ftest));

  // R2
  min_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (min_stb && min_idx == MIN_W'(CYCLE_MIN - 1)) |=> (min_idx == '0));

  // R3
  zero_mag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (min_stb && trim_mag == '0) |=> !arm);

  // R5
  blank_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_active && !halt) |=> $stable(low_cnt));
endmodule

bind cal_trim_divider cal_trim_divider_chk #(
  .LOW_W(LOW_W), .MAG_W(MAG_W), .CYCLE_MIN(CYCLE_MIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .halt(halt), .min_stb(min_stb), .trim_mag(trim_mag),
  .sec_tick(sec_tick), .ftest(ftest), .min_idx(min_idx), .arm(arm),
  .blank_active(blank_active), .low_cnt(low_cnt));

// File: tb/cal_trim_divider_bench.sv
`timescale 1ns/1ps
module cal_trim_divider_bench;
  localparam int HI_DIV = 8;
  localparam int NOM    = HI_DIV * 256;
  localparam int FAST   = NOM - 256;
  localparam int SLOW   = NOM + 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b1;
  logic [4:0] trim_mag = '0;
  logic       trim_pos = 1'b0;
  logic       halt = 1'b0;
  logic       min_stb = 1'b0;
  logic       sec_tick, ftest;

  int  checks = 0;
  int  errors = 0;
  bit  gap = 1'b0;
  bit  done = 1'b0;
  int  exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  cal_trim_divider #(.HI_DIV(HI_DIV)) u_cal_trim_divider (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .trim_mag(trim_mag),
    .trim_pos(trim_pos), .halt(halt), .min_stb(min_stb),
    .sec_tick(sec_tick), .ftest(ftest));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic step();
    @(negedge clk);
    osc_en = gap ? ~osc_en : 1'b1;
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      min_stb = 1'b1;
      step();
    end
    min_stb = 1'b0;
  endtask

  task automatic wait_tick();
    do step(); while (!sec_tick);
  endtask

  // Driver: sets up one second, pushes its expected length, waits for its tick.
  task automatic run_second(input int mag, input bit pos, input int delay, input int nstb,
                            input int expect_len, input string tag);
    trim_mag = 5'(mag);
    trim_pos = pos;
    for (int i = 0; i < delay; i++) step();
    strobe(nstb);
    exp_q.push_back(expect_len);
    tag_q.push_back(tag);
    wait_tick();
  endtask

  // Monitor: measures tick-to-tick intervals in clocks and compares them.
  int mcnt = 0;
  always @(negedge clk) begin
    if (!rst_n) mcnt = 0;
    else begin
      mcnt++;
      if (sec_tick) begin
        if (exp_q.size() > 0) begin
          automatic int e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(mcnt == e, t, mcnt, e);
        end
        mcnt = 0;
      end
    end
  end

  // Test-output monitor: counts enables between ftest edges (R7).
  logic en_q = 1'b0, halt_q = 1'b0;
  always @(posedge clk) begin
    en_q   <= osc_en;
    halt_q <= halt;
  end
  int  ecnt = 0;
  logic ft_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      ecnt = 0;
      ft_prev = 1'b0;
    end else begin
      if (halt_q) ecnt = 0;
      else begin
        if (en_q) ecnt++;
        if (ftest != ft_prev) begin
          chk(ecnt == 32, "R7", ecnt, 32);
          ecnt = 0;
        end
      end
      ft_prev = ftest;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    chk(sec_tick == 1'b0, "R1", sec_tick, 0);
    chk(ftest == 1'b0, "R7", ftest, 0);

    run_second(0, 1'b0, 0, 0, NOM, "R1");     // plain second, minute index still 63
    run_second(1, 1'b1, 0, 1, FAST, "R4");    // index 0, inside window of 2
    run_second(1, 1'b1, 0, 1, FAST, "R3");    // index 1, last minute in window
    run_second(1, 1'b1, 0, 1, NOM, "R3");     // index 2, first minute outside
    run_second(3, 1'b0, 0, 1, SLOW, "R5");    // index 3, window of 6, slow down
    run_second(3, 1'b0, 0, 3, NOM, "R3");     // index 6, outside
    run_second(31, 1'b1, 0, 55, FAST, "R3");  // index 61, last corrected minute
    run_second(31, 1'b1, 0, 1, NOM, "R3");    // index 62, never corrected
    run_second(31, 1'b1, 0, 1, NOM, "R2");    // index 63
    run_second(31, 1'b0, 0, 1, SLOW, "R2");   // wrap to index 0, corrected
    run_second(5, 1'b1, 0, 0, NOM, "R6");     // arming already used
    run_second(2, 1'b1, 300, 1, NOM, "R6");   // late strobe, index 1: no effect now
    run_second(2, 1'b1, 0, 0, FAST, "R6");    // ...moves to the next second

    gap = 1'b1;
    osc_en = 1'b0;
    run_second(0, 1'b0, 0, 0, 2 * NOM, "R9");
    gap = 1'b0;
    osc_en = 1'b1;

    // R8: halt, arm during halt (index 2 inside window of 4), then release
    halt = 1'b1;
    trim_mag = 5'd2;
    trim_pos = 1'b1;
    for (int i = 0; i < 200; i++) begin
      step();
      if (i == 50) strobe(1);
      if (sec_tick) chk(1'b0, "R8", 1, 0);
    end
    chk(sec_tick == 1'b0, "R8", sec_tick, 0);
    chk(ftest == 1'b0, "R8", ftest, 0);
    halt = 1'b0;
    begin
      automatic int cnt = 0;
      do begin
        step();
        cnt++;
      end while (!sec_tick && cnt < 3 * NOM);
      chk(cnt == FAST, "R8", cnt, FAST);
    end
    repeat (5) step();
    finish_run();
  end
endmodule